// File: doc/BRIEF.md
# CAN Receive Acceptance Filter Router

This block decides where each received CAN frame goes. It takes the frame's identifier and its ID type, which is either an 11-bit standard ID or a 29-bit extended ID. It then walks the list of filter elements that belongs to that ID type, one element per clock, starting at element 0. The first enabled element whose masked identifier equals the frame's masked identifier ends the walk. That element's destination selector sends the frame to one of four places: a numbered dedicated receive buffer slot, receive FIFO 0, receive FIFO 1, or reject. A frame that no element accepts follows a global fallback setting instead.

The block keeps the routing state that software polls. There is one new-data flag per dedicated buffer slot, cleared by writing 1 to it. Each of the two FIFOs has a fill counter of stored, unread frames, lowered by a read-acknowledge strobe, and a sticky overflow flag for frames lost to a full FIFO. The frame payload storage, the bit-level protocol engine and interrupt generation are handled elsewhere. Those parts consume the `done` result that this block produces.

Filter elements are written through a simple configuration port before reception starts. The number of standard filters, the number of extended filters, the number of buffer slots and the FIFO depth are all parameters.

Top module: `can_rx_router`

## Requirements
- R1: A frame with `frmIsExt`=1 is compared only against the extended list on all 29 ID bits. A frame with `frmIsExt`=0 is compared only against the standard list on `frmId[10:0]`, and bits [28:11] of a standard frame's ID have no effect.
- R2: Elements are tested in ascending index order, one per clock. The first accepting element alone decides the route. If element k accepts, `doneValid` is high in the cycle that follows the (k+1)-th rising edge after the capture edge.
- R3: An element whose enable bit is 0 never accepts a frame, and the scan moves on to the next index.
- R4: An element accepts when `(frmId & mask) == (filterId & mask)`, with every bit that is 0 in the mask ignored.
- R5: The element destination codes are: 0 = buffer slot `cfgBufIdx`, 1 = FIFO 0, 2 = FIFO 1, 3 = reject. For a reject, `doneDest` is 3 and `doneDiscard` is 1.
- R6: If no element of the list accepts, the route comes from `nonMatchDest`: 1 = FIFO 0, 2 = FIFO 1, 0 or 3 = discard. `doneValid` then follows the N-th edge after capture, where N is the length of the list that was scanned.
- R7: A frame routed to buffer slot i sets `newData[i]`. A 1 on `newDataClr[i]` clears only bit i. When a set and a clear of the same bit arrive in the same cycle, the set wins.
- R8: Each FIFO level rises by one for every frame stored in that FIFO and falls by one for every read-acknowledge pulse. An acknowledge at level 0 is ignored. A store and an acknowledge in the same cycle leave the level unchanged.
- R9: A frame routed to a FIFO whose level equals `FIFO_DEPTH` is dropped. The level stays where it is, `doneDiscard` is 1, and that FIFO's bit in `fifoOvf` is set and stays set until a 1 is written to the matching bit of `fifoOvfClr`.
- R10: A frame is captured only when `frmValid` is 1 while `scanBusy` is 0. `scanBusy` is 1 for the whole scan, and frames presented while it is 1 are ignored.
- R11: After reset, `scanBusy`, `doneValid`, `newData`, both FIFO levels and `fifoOvf` are all 0.
- R12: Every captured frame produces exactly one single-cycle `doneValid` pulse, which carries `doneDest`, `doneBufIdx` and `doneDiscard`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Write strobe for one filter element |
| cfgIsExt | input | 1 | Selects the list to write: 1 = extended, 0 = standard |
| cfgIdx | input | IDX_W | Index of the element within the list |
| cfgEnable | input | 1 | Enable bit of the element |
| cfgId | input | 29 | Identifier to compare against |
| cfgMask | input | 29 | Compare mask; a 1 means the bit is compared |
| cfgDest | input | 2 | Destination code (R5) |
| cfgBufIdx | input | BUF_W | Buffer slot used when the destination is 0 |
| nonMatchDest | input | 2 | Fallback route for frames no element accepts (R6) |
| frmValid | input | 1 | A received frame is present |
| frmIsExt | input | 1 | ID type of the frame |
| frmId | input | 29 | Frame identifier; standard IDs sit in [10:0] |
| scanBusy | output | 1 | A scan is in progress |
| doneValid | output | 1 | Single-cycle pulse carrying the route result |
| doneDest | output | 2 | Chosen destination code |
| doneBufIdx | output | BUF_W | Slot for a buffer route |
| doneDiscard | output | 1 | The frame was not stored |
| newData | output | NUM_BUF | New-data flag for each slot |
| newDataClr | input | NUM_BUF | Write-1-to-clear for the new-data flags |
| fifo0Level | output | LVL_W | Fill level of FIFO 0 |
| fifo1Level | output | LVL_W | Fill level of FIFO 1 |
| fifo0RdAck | input | 1 | FIFO 0 read acknowledge |
| fifo1RdAck | input | 1 | FIFO 1 read acknowledge |
| fifoOvf | output | 2 | Sticky overflow flags, bit f for FIFO f |
| fifoOvfClr | input | 2 | Write-1-to-clear for the overflow flags |

## Verification
The bench aims at the ordering corners. In one case a later element would also accept but is shadowed by an earlier one. In another, a disabled element would have matched and must be skipped, so a wrong design either routes to the shadowed or disabled element's destination or reports a different scan latency. A standard and an extended frame share the same ID value to catch a design that mixes the two lists, and a standard frame carries junk in its upper ID bits to catch a design that compares them. The bench also drives the same-cycle collisions: a slot clear during a store, and a read acknowledge during a FIFO store. A design with the wrong priority loses a flag or moves the level. It then fills a FIFO past its depth and pushes a second frame during a busy scan, to catch a counter that wraps, an overflow flag that is not sticky, and a scan that restarts in mid-flight.

// File: rtl/can_rx_router_pkg.sv
package can_rx_router_pkg;

  // destination codes shared by filter elements and the done result
  typedef enum logic [1:0] {
    DEST_BUF   = 2'd0,
    DEST_FIFO0 = 2'd1,
    DEST_FIFO1 = 2'd2,
    DEST_DROP  = 2'd3
  } rxDest_e;

  // strobes from the scan control to the datapath
  typedef struct packed {
    logic capture;  // latch the presented frame
    logic finish;   // scan ends this cycle, commit the route
    logic hit;      // current element accepted the frame
  } scanStrobe_t;

endpackage

// File: rtl/can_rx_ctrl.sv
module can_rx_ctrl
  import can_rx_router_pkg::*;
#(
  parameter int NUM_STD = 4,
  parameter int NUM_EXT = 4,
  localparam int MAX_F = (NUM_STD > NUM_EXT) ? NUM_STD : NUM_EXT,
  localparam int IDX_W = (MAX_F > 1) ? $clog2(MAX_F) : 1
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             frmValid,
  input  logic             frmIsExt,
  input  logic             elemHit,
  output logic             scanBusy,
  output logic [IDX_W-1:0] scanIdx,
  output scanStrobe_t      strobes
);

  localparam logic [IDX_W-1:0] LAST_STD = IDX_W'(NUM_STD - 1);
  localparam logic [IDX_W-1:0] LAST_EXT = IDX_W'(NUM_EXT - 1);

  logic             busyQ;
  logic             extQ;
  logic [IDX_W-1:0] idxQ;
  logic [IDX_W-1:0] lastIdx;

  assign lastIdx = extQ ? LAST_EXT : LAST_STD;

  always_comb begin
    strobes.capture = frmValid && !busyQ;
    strobes.hit     = busyQ && elemHit;
    strobes.finish  = busyQ && (elemHit || (idxQ == lastIdx));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ <= 1'b0;
      extQ  <= 1'b0;
      idxQ  <= '0;
    end else if (strobes.capture) begin
      busyQ <= 1'b1;
      extQ  <= frmIsExt;
      idxQ  <= '0;
    end else if (strobes.finish) begin
      busyQ <= 1'b0;
    end else if (busyQ) begin
      idxQ <= idxQ + 1'b1;
    end
  end

  assign scanBusy = busyQ;
  assign scanIdx  = idxQ;

  // R10
  finish_idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.finish |=> !scanBusy);

  // R10
  capture_start_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.capture |=> (scanBusy && scanIdx == '0));

  // R2
  idx_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    scanBusy |-> (scanIdx <= lastIdx));

endmodule

// File: rtl/can_rx_dpath.sv
module can_rx_dpath
  import can_rx_router_pkg::*;
#(
  parameter int NUM_STD    = 4,
  parameter int NUM_EXT    = 4,
  parameter int NUM_BUF    = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int MAX_F = (NUM_STD > NUM_EXT) ? NUM_STD : NUM_EXT,
  localparam int IDX_W = (MAX_F > 1) ? $clog2(MAX_F) : 1,
  localparam int BUF_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             cfgWrEn,
  input  logic             cfgIsExt,
  input  logic [IDX_W-1:0] cfgIdx,
  input  logic             cfgEnable,
  input  logic [28:0]      cfgId,
  input  logic [28:0]      cfgMask,
  input  logic [1:0]       cfgDest,
  input  logic [BUF_W-1:0] cfgBufIdx,
  input  logic [1:0]       nonMatchDest,
  input  logic             frmIsExt,
  input  logic [28:0]      frmId,
  input  scanStrobe_t      strobes,
  input  logic [IDX_W-1:0] scanIdx,
  output logic             elemHit,
  output logic             doneValid,
  output logic [1:0]       doneDest,
  output logic [BUF_W-1:0] doneBufIdx,
  output logic             doneDiscard,
  output logic [NUM_BUF-1:0] newData,
  input  logic [NUM_BUF-1:0] newDataClr,
  output logic [LVL_W-1:0] fifoLevel [2],
  input  logic [1:0]       fifoRdAck,
  output logic [1:0]       fifoOvf,
  input  logic [1:0]       fifoOvfClr
);

  localparam logic [LVL_W-1:0] LVL_FULL = LVL_W'(FIFO_DEPTH);
  localparam logic [28:0]      STD_BITS = 29'h7FF;

  typedef struct packed {
    logic             en;
    logic [28:0]      id;
    logic [28:0]      mask;
    logic [1:0]       dest;
    logic [BUF_W-1:0] bufIdx;
  } filtElem_t;

  filtElem_t stdTab [NUM_STD];
  filtElem_t extTab [NUM_EXT];
  filtElem_t cfgElem;
  filtElem_t curElem;

  logic        frmExtQ;
  logic [28:0] frmIdQ;
  logic [28:0] cmpMask;
  logic [1:0]  routeDest;
  logic [BUF_W-1:0] routeBuf;
  logic        storeBuf;
  logic [1:0]  storeFifo;
  logic [1:0]  fifoFull;
  logic [1:0]  fifoInc;
  logic [1:0]  fifoDec;
  logic [NUM_BUF-1:0] setVec;
  logic        dropFull;

  // ---------------- filter element storage ----------------
  always_comb begin
    cfgElem.en     = cfgEnable;
    cfgElem.id     = cfgId;
    cfgElem.mask   = cfgMask;
    cfgElem.dest   = cfgDest;
    cfgElem.bufIdx = cfgBufIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < NUM_STD; i++) stdTab[i] <= '0;
      for (int i = 0; i < NUM_EXT; i++) extTab[i] <= '0;
    end else if (cfgWrEn) begin
      for (int i = 0; i < NUM_STD; i++)
        if (!cfgIsExt && cfgIdx == IDX_W'(i)) stdTab[i] <= cfgElem;
      for (int i = 0; i < NUM_EXT; i++)
        if (cfgIsExt && cfgIdx == IDX_W'(i)) extTab[i] <= cfgElem;
    end
  end

  // ---------------- captured frame ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      frmExtQ <= 1'b0;
      frmIdQ  <= '0;
    end else if (strobes.capture) begin
      frmExtQ <= frmIsExt;
      frmIdQ  <= frmId;
    end
  end

  // ---------------- element select and compare ----------------
  always_comb begin
    curElem = '0;
    if (frmExtQ) begin
      for (int i = 0; i < NUM_EXT; i++)
        if (scanIdx == IDX_W'(i)) curElem = extTab[i];
    end else begin
      for (int i = 0; i < NUM_STD; i++)
        if (scanIdx == IDX_W'(i)) curElem = stdTab[i];
    end
  end

  assign cmpMask = frmExtQ ? curElem.mask : (curElem.mask & STD_BITS);
  assign elemHit = curElem.en && (((frmIdQ ^ curElem.id) & cmpMask) == '0);

  // ---------------- routing decision ----------------
  always_comb begin
    routeBuf = curElem.bufIdx;
    if (strobes.hit) begin
      routeDest = curElem.dest;
    end else begin
      routeBuf = '0;
      if (nonMatchDest == DEST_FIFO0 || nonMatchDest == DEST_FIFO1)
        routeDest = nonMatchDest;
      else
        routeDest = DEST_DROP;
    end
  end

  always_comb begin
    storeBuf     = strobes.finish && (routeDest == DEST_BUF);
    storeFifo[0] = strobes.finish && (routeDest == DEST_FIFO0);
    storeFifo[1] = strobes.finish && (routeDest == DEST_FIFO1);
    setVec       = '0;
    if (storeBuf) setVec[routeBuf] = 1'b1;
    for (int f = 0; f < 2; f++) begin
      fifoFull[f] = (fifoLevel[f] == LVL_FULL);
      fifoInc[f]  = storeFifo[f] && !fifoFull[f];
      fifoDec[f]  = fifoRdAck[f] && (fifoLevel[f] != '0);
    end
    dropFull = (storeFifo[0] && fifoFull[0]) || (storeFifo[1] && fifoFull[1]);
  end

  // ---------------- done result ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      doneValid   <= 1'b0;
      doneDest    <= '0;
      doneBufIdx  <= '0;
      doneDiscard <= 1'b0;
    end else begin
      doneValid <= strobes.finish;
      if (strobes.finish) begin
        doneDest    <= routeDest;
        doneBufIdx  <= routeBuf;
        doneDiscard <= (routeDest == DEST_DROP) || dropFull;
      end
    end
  end

  // ---------------- new-data flags ----------------
  always_ff @(posedge clk) begin
    if (!rstN) newData <= '0;
    else       newData <= (newData & ~newDataClr) | setVec;
  end

  // ---------------- FIFO fill levels and overflow ----------------
  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int f = 0; f < 2; f++) fifoLevel[f] <= '0;
      fifoOvf <= '0;
    end else begin
      for (int f = 0; f < 2; f++) begin
        if (fifoInc[f] && !fifoDec[f])      fifoLevel[f] <= fifoLevel[f] + 1'b1;
        else if (fifoDec[f] && !fifoInc[f]) fifoLevel[f] <= fifoLevel[f] - 1'b1;
        fifoOvf[f] <= (fifoOvf[f] & ~fifoOvfClr[f]) | (storeFifo[f] && fifoFull[f]);
      end
    end
  end

  // R7
  newdata_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (doneValid && doneDest == DEST_BUF && !doneDiscard) |-> newData[doneBufIdx]);

  // R12
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);

  // R8
  level0_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel[0] <= LVL_FULL);

  // R8
  level1_bound_chk: assert property (@(posedge clk) disable iff (!rstN)
    fifoLevel[1] <= LVL_FULL);

  // R9
  ovf0_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (storeFifo[0] && fifoFull[0] && !fifoRdAck[0]) |=> (fifoOvf[0] && fifoLevel[0] == LVL_FULL));

  // R9
  ovf1_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (storeFifo[1] && fifoFull[1] && !fifoRdAck[1]) |=> (fifoOvf[1] && fifoLevel[1] == LVL_FULL));

endmodule

// File: rtl/can_rx_router.sv
module can_rx_router
  import can_rx_router_pkg::*;
#(
  parameter int NUM_STD    = 4,
  parameter int NUM_EXT    = 4,
  parameter int NUM_BUF    = 8,
  parameter int FIFO_DEPTH = 4,
  localparam int MAX_F = (NUM_STD > NUM_EXT) ? NUM_STD : NUM_EXT,
  localparam int IDX_W = (MAX_F > 1) ? $clog2(MAX_F) : 1,
  localparam int BUF_W = (NUM_BUF > 1) ? $clog2(NUM_BUF) : 1,
  localparam int LVL_W = $clog2(FIFO_DEPTH + 1)
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               cfgWrEn,
  input  logic               cfgIsExt,
  input  logic [IDX_W-1:0]   cfgIdx,
  input  logic               cfgEnable,
  input  logic [28:0]        cfgId,
  input  logic [28:0]        cfgMask,
  input  logic [1:0]         cfgDest,
  input  logic [BUF_W-1:0]   cfgBufIdx,
  input  logic [1:0]         nonMatchDest,
  input  logic               frmValid,
  input  logic               frmIsExt,
  input  logic [28:0]        frmId,
  output logic               scanBusy,
  output logic               doneValid,
  output logic [1:0]         doneDest,
  output logic [BUF_W-1:0]   doneBufIdx,
  output logic               doneDiscard,
  output logic [NUM_BUF-1:0] newData,
  input  logic [NUM_BUF-1:0] newDataClr,
  output logic [LVL_W-1:0]   fifo0Level,
  output logic [LVL_W-1:0]   fifo1Level,
  input  logic               fifo0RdAck,
  input  logic               fifo1RdAck,
  output logic [1:0]         fifoOvf,
  input  logic [1:0]         fifoOvfClr
);

  scanStrobe_t      strobes;
  logic [IDX_W-1:0] scanIdx;
  logic             elemHit;
  logic [LVL_W-1:0] fifoLevel [2];

  can_rx_ctrl #(
    .NUM_STD(NUM_STD),
    .NUM_EXT(NUM_EXT)
  ) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .frmValid (frmValid),
    .frmIsExt (frmIsExt),
    .elemHit  (elemHit),
    .scanBusy (scanBusy),
    .scanIdx  (scanIdx),
    .strobes  (strobes)
  );

  can_rx_dpath #(
    .NUM_STD   (NUM_STD),
    .NUM_EXT   (NUM_EXT),
    .NUM_BUF   (NUM_BUF),
    .FIFO_DEPTH(FIFO_DEPTH)
  ) u_dpath (
    .clk          (clk),
    .rstN         (rstN),
    .cfgWrEn      (cfgWrEn),
    .cfgIsExt     (cfgIsExt),
    .cfgIdx       (cfgIdx),
    .cfgEnable    (cfgEnable),
    .cfgId        (cfgId),
    .cfgMask      (cfgMask),
    .cfgDest      (cfgDest),
    .cfgBufIdx    (cfgBufIdx),
    .nonMatchDest (nonMatchDest),
    .frmIsExt     (frmIsExt),
    .frmId        (frmId),
    .strobes      (strobes),
    .scanIdx      (scanIdx),
    .elemHit      (elemHit),
    .doneValid    (doneValid),
    .doneDest     (doneDest),
    .doneBufIdx   (doneBufIdx),
    .doneDiscard  (doneDiscard),
    .newData      (newData),
    .newDataClr   (newDataClr),
    .fifoLevel    (fifoLevel),
    .fifoRdAck    ({fifo1RdAck, fifo0RdAck}),
    .fifoOvf      (fifoOvf),
    .fifoOvfClr   (fifoOvfClr)
  );

  assign fifo0Level = fifoLevel[0];
  assign fifo1Level = fifoLevel[1];

endmodule

// File: tb/can_rx_router_tb.sv
`timescale 1ns/1ps
module can_rx_router_tb;
  import can_rx_router_pkg::*;

  localparam int NUM_STD = 4, NUM_EXT = 4, NUM_BUF = 8, FIFO_DEPTH = 4;
  localparam int IDX_W = 2, BUF_W = 3, LVL_W = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic rstN;
  logic cfgWrEn, cfgIsExt, cfgEnable;
  logic [IDX_W-1:0] cfgIdx;
  logic [28:0] cfgId, cfgMask, frmId;
  logic [1:0] cfgDest, nonMatchDest, doneDest, fifoOvf, fifoOvfClr;
  logic [BUF_W-1:0] cfgBufIdx, doneBufIdx;
  logic frmValid, frmIsExt, scanBusy, doneValid, doneDiscard;
  logic [NUM_BUF-1:0] newData, newDataClr;
  logic [LVL_W-1:0] fifo0Level, fifo1Level;
  logic fifo0RdAck, fifo1RdAck;

  can_rx_router #(
    .NUM_STD(NUM_STD), .NUM_EXT(NUM_EXT), .NUM_BUF(NUM_BUF), .FIFO_DEPTH(FIFO_DEPTH)
  ) u_dut (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgIsExt(cfgIsExt), .cfgIdx(cfgIdx),
    .cfgEnable(cfgEnable), .cfgId(cfgId), .cfgMask(cfgMask), .cfgDest(cfgDest),
    .cfgBufIdx(cfgBufIdx), .nonMatchDest(nonMatchDest), .frmValid(frmValid),
    .frmIsExt(frmIsExt), .frmId(frmId), .scanBusy(scanBusy), .doneValid(doneValid),
    .doneDest(doneDest), .doneBufIdx(doneBufIdx), .doneDiscard(doneDiscard),
    .newData(newData), .newDataClr(newDataClr), .fifo0Level(fifo0Level),
    .fifo1Level(fifo1Level), .fifo0RdAck(fifo0RdAck), .fifo1RdAck(fifo1RdAck),
    .fifoOvf(fifoOvf), .fifoOvfClr(fifoOvfClr)
  );

  int checks = 0;
  int fails = 0;
  int gotLat;
  logic [1:0] gotDest;
  logic [BUF_W-1:0] gotBuf;
  logic gotDisc;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic endRun();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 100000);
    checks++;
    fails++;
    $display("FAIL watchdog: actual=hung expected=finished");
    endRun();
  end

  task automatic cfgFilter(input logic isExt, input int idx, input logic en,
                           input logic [28:0] id, input logic [28:0] mask,
                           input logic [1:0] dest, input int bufIdx);
    @(negedge clk);
    cfgWrEn = 1'b1; cfgIsExt = isExt; cfgIdx = IDX_W'(idx); cfgEnable = en;
    cfgId = id; cfgMask = mask; cfgDest = dest; cfgBufIdx = BUF_W'(bufIdx);
    @(negedge clk);
    cfgWrEn = 1'b0;
  endtask

  // side strobes are held during the cycle that ends with the done edge
  task automatic sendFrame(input logic isExt, input logic [28:0] id, input int expLat,
                           input logic [1:0] ack, input logic [NUM_BUF-1:0] clr);
    int cnt;
    @(negedge clk);
    frmValid = 1'b1; frmIsExt = isExt; frmId = id;
    @(posedge clk);
    @(negedge clk);
    frmValid = 1'b0;
    cnt = 0;
    if (expLat == 1) begin
      fifo0RdAck = ack[0]; fifo1RdAck = ack[1]; newDataClr = clr;
    end
    forever begin
      @(posedge clk);
      cnt++;
      @(negedge clk);
      fifo0RdAck = 1'b0; fifo1RdAck = 1'b0; newDataClr = '0;
      if (doneValid || cnt > 40) break;
      if (cnt == expLat - 1) begin
        fifo0RdAck = ack[0]; fifo1RdAck = ack[1]; newDataClr = clr;
      end
    end
    gotLat = cnt; gotDest = doneDest; gotBuf = doneBufIdx; gotDisc = doneDiscard;
  endtask

  typedef struct packed {
    logic        isExt;
    logic [28:0] id;
    logic [1:0]  dest;
    logic [2:0]  bufIdx;
    logic        disc;
    logic [7:0]  lat;
  } vec_t;

  // R1 (6, 11), R2 (1, 2), R3 (3), R4 (8), R5 (4), R6 (5, 10)
  localparam vec_t VEC [11] = '{
    '{1'b0, 29'h100,      2'd0, 3'd3, 1'b0, 8'd1},
    '{1'b0, 29'h205,      2'd1, 3'd0, 1'b0, 8'd3},
    '{1'b0, 29'h200,      2'd1, 3'd0, 1'b0, 8'd3},
    '{1'b0, 29'h300,      2'd3, 3'd0, 1'b1, 8'd4},
    '{1'b0, 29'h555,      2'd2, 3'd0, 1'b0, 8'd4},
    '{1'b1, 29'h100,      2'd2, 3'd0, 1'b0, 8'd2},
    '{1'b1, 29'h1ABCDEF0, 2'd0, 3'd5, 1'b0, 8'd1},
    '{1'b1, 29'h1ABCDEF1, 2'd0, 3'd6, 1'b0, 8'd3},
    '{1'b1, 29'h0,        2'd1, 3'd0, 1'b0, 8'd4},
    '{1'b1, 29'h123,      2'd2, 3'd0, 1'b0, 8'd4},
    '{1'b0, 29'h0100100,  2'd0, 3'd3, 1'b0, 8'd1}
  };

  initial begin
    int doneCnt;
    rstN = 1'b0; cfgWrEn = 1'b0; cfgIsExt = 1'b0; cfgIdx = '0; cfgEnable = 1'b0;
    cfgId = '0; cfgMask = '0; cfgDest = '0; cfgBufIdx = '0; nonMatchDest = 2'd2;
    frmValid = 1'b0; frmIsExt = 1'b0; frmId = '0; newDataClr = '0;
    fifo0RdAck = 1'b0; fifo1RdAck = 1'b0; fifoOvfClr = '0;
    repeat (3) @(negedge clk);
    // R11 reset state
    chk("R11 scanBusy", int'(scanBusy), 0);
    chk("R11 doneValid", int'(doneValid), 0);
    chk("R11 newData", int'(newData), 0);
    chk("R11 fifo0Level", int'(fifo0Level), 0);
    chk("R11 fifo1Level", int'(fifo1Level), 0);
    chk("R11 fifoOvf", int'(fifoOvf), 0);
    rstN = 1'b1;

    cfgFilter(1'b0, 0, 1'b1, 29'h100, 29'h7FF, DEST_BUF, 3);
    cfgFilter(1'b0, 1, 1'b0, 29'h200, 29'h7FF, DEST_FIFO1, 0);
    cfgFilter(1'b0, 2, 1'b1, 29'h200, 29'h7F0, DEST_FIFO0, 0);
    cfgFilter(1'b0, 3, 1'b1, 29'h300, 29'h7FF, DEST_DROP, 0);
    cfgFilter(1'b1, 0, 1'b1, 29'h1ABCDEF0, 29'h1FFFFFFF, DEST_BUF, 5);
    cfgFilter(1'b1, 1, 1'b1, 29'h100, 29'h1FFFFFFF, DEST_FIFO1, 0);
    cfgFilter(1'b1, 2, 1'b1, 29'h10000000, 29'h10000000, DEST_BUF, 6);
    cfgFilter(1'b1, 3, 1'b1, 29'h0, 29'h1FFFFFFF, DEST_FIFO0, 0);

    for (int v = 0; v < 11; v++) begin
      sendFrame(VEC[v].isExt, VEC[v].id, int'(VEC[v].lat), 2'b00, '0);
      chk($sformatf("R2 R6 latency vector %0d", v), gotLat, int'(VEC[v].lat));
      chk($sformatf("R1 R5 dest vector %0d", v), int'(gotDest), int'(VEC[v].dest));
      chk($sformatf("R5 discard vector %0d", v), int'(gotDisc), int'(VEC[v].disc));
      if (VEC[v].dest == DEST_BUF)
        chk($sformatf("R4 bufIdx vector %0d", v), int'(gotBuf), int'(VEC[v].bufIdx));
    end
    chk("R7 flags after table", int'(newData), 'h68);
    chk("R8 fifo0 level after table", int'(fifo0Level), 3);
    chk("R8 fifo1 level after table", int'(fifo1Level), 3);

    // R7 set wins over a clear in the same cycle
    sendFrame(1'b0, 29'h100, 1, 2'b00, 8'h08);
    chk("R7 set wins", int'(newData), 'h68);
    @(negedge clk); newDataClr = 8'h20;
    @(negedge clk); newDataClr = '0;
    chk("R7 w1c one bit", int'(newData), 'h48);
    @(negedge clk); newDataClr = 8'h08;
    @(negedge clk); newDataClr = '0;
    chk("R7 w1c slot 3", int'(newData), 'h40);

    // R9 overflow on FIFO 1
    sendFrame(1'b1, 29'h100, 2, 2'b00, '0);
    chk("R8 fifo1 fills", int'(fifo1Level), 4);
    chk("R9 no discard below full", int'(gotDisc), 0);
    sendFrame(1'b1, 29'h100, 2, 2'b00, '0);
    chk("R9 full discard", int'(gotDisc), 1);
    chk("R9 full dest", int'(gotDest), 2);
    chk("R9 level held", int'(fifo1Level), 4);
    chk("R9 ovf set", int'(fifoOvf), 2);

    // R8 acknowledge and simultaneous store+ack
    @(negedge clk); fifo1RdAck = 1'b1;
    @(negedge clk); fifo1RdAck = 1'b0;
    chk("R8 ack decrements", int'(fifo1Level), 3);
    sendFrame(1'b1, 29'h100, 2, 2'b10, '0);
    chk("R8 store+ack unchanged", int'(fifo1Level), 3);
    chk("R9 ovf sticky", int'(fifoOvf), 2);
    @(negedge clk); fifoOvfClr = 2'b10;
    @(negedge clk); fifoOvfClr = '0;
    chk("R9 ovf cleared", int'(fifoOvf), 0);
    @(negedge clk); fifo0RdAck = 1'b1;
    repeat (4) @(negedge clk);
    fifo0RdAck = 1'b0;
    chk("R8 no underflow", int'(fifo0Level), 0);

    // R6 fallback choices
    nonMatchDest = 2'd0;
    sendFrame(1'b0, 29'h555, 4, 2'b00, '0);
    chk("R6 fallback discard", int'(gotDisc), 1);
    chk("R6 discard keeps fifo0", int'(fifo0Level), 0);
    chk("R6 discard keeps fifo1", int'(fifo1Level), 3);
    nonMatchDest = 2'd1;
    sendFrame(1'b1, 29'h123, 4, 2'b00, '0);
    chk("R6 fallback fifo0 dest", int'(gotDest), 1);
    chk("R6 fallback fifo0 level", int'(fifo0Level), 1);

    // R10 frame presented during a scan is ignored
    nonMatchDest = 2'd3;
    @(negedge clk);
    frmValid = 1'b1; frmIsExt = 1'b0; frmId = 29'h555;
    @(posedge clk);
    @(negedge clk);
    frmId = 29'h100;
    chk("R10 busy during scan", int'(scanBusy), 1);
    @(negedge clk);
    frmValid = 1'b0;
    doneCnt = 0;
    for (int c = 0; c < 8; c++) begin
      if (doneValid) doneCnt++;
      @(negedge clk);
    end
    chk("R12 one done pulse", doneCnt, 1);
    chk("R10 ignored frame left slot 3 clear", int'(newData), 'h40);
    chk("R10 idle after scan", int'(scanBusy), 0);

    endRun();
  end

endmodule